// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox Unit

This block holds a set of 32-bit doorbell words for each core of a multi-core cluster, used to signal inter-processor interrupts. Any core can raise doorbell bits in another core's mailbox through a set view of the address space. Writing a word there ORs it into the mailbox. The owning core reads its mailbox through a separate clear view. It acknowledges bits by writing ones to that same clear-view address. Each core also has an enable register that chooses which of its mailboxes raise its pending line.

Several bus masters reach the register space at once, one request port each. Every port is a valid/ready request channel paired with a valid/ready response channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Exactly one response follows on the next cycle. `req_ready` is low only while that port's earlier response is still waiting for `rsp_ready`. The response holds its data until it is taken. The per-core `mbox_pending` lines go to the interrupt router.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset every mailbox and every enable register is zero, `mbox_pending` is low, no response is valid and every `req_ready` is high.
- R2: A write to the set view at byte address 0x80 + 16*core + 4*mailbox ORs the write data into that mailbox.
- R3: The clear view at byte address 0xC0 + 16*core + 4*mailbox reads back the mailbox contents. A write there clears exactly the bits that are 1 in the write data.
- R4: The enable register of a core sits at byte address 4*core. Bit m enables mailbox m. Write data bits at or above the mailbox count are dropped. A read returns the enable bits zero-extended.
- R5: `mbox_pending[c]` is high exactly when some mailbox m of core c is nonzero and its enable bit m is set. It changes on the same edge that accepts the write causing the change.
- R6: When one port sets and another clears the same mailbox bit in the same cycle, the bit ends up set.
- R7: When several ports write the same enable register in one cycle, the lowest-numbered port's data is kept.
- R8: A request accepted on an edge gives `rsp_valid` on the next cycle. `req_ready` equals not `rsp_valid` or `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response and its data stay unchanged. Writes respond with zero data.
- R9: A read returns the register value from before any write accepted on the same edge by another port.
- R10: Reads of the set view and of unmapped addresses return zero. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORT | Request valid, one bit per port |
| req_ready | output | NPORT | Request ready, one bit per port |
| req_write | input | NPORT | 1 = write, 0 = read |
| req_addr | input | NPORT*AW | Byte addresses, port p in slice p*AW |
| req_wdata | input | NPORT*DW | Write data, port p in slice p*DW |
| rsp_valid | output | NPORT | Response valid |
| rsp_ready | input | NPORT | Response accepted by the master |
| rsp_rdata | output | NPORT*DW | Read data, port p in slice p*DW |
| mbox_pending | output | NCORE | Per-core mailbox interrupt pending |

## Verification
A table of single-port accesses walks the set, clear and enable views across several cores and mailboxes. It uses partial clears, enables set before and after the doorbell arrives, and enable data with ignored upper bits. The pending line is compared after every row, which separates a working enable mask from a plain nonzero test. Directed two-port cases drive the same bit with a set and a clear in one cycle, and the same enable register from both ports. They also pair a read with a write to the same mailbox. These cases tell set-wins, lowest-port-wins and old-value reads apart from the opposite choices. A held response with a second request waiting shows whether a stalled port loses, duplicates or delays that request.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CTRL = 2'd1,
    REG_SET  = 2'd2,
    REG_CLR  = 2'd3
  } reg_kind_e;

  localparam int BANK_BYTES = 16;
  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int NCORE     = 4,
  parameter int NMBOX     = 4,
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int CTRL_BASE = 0,
  parameter int SET_BASE  = 128,
  parameter int CLR_BASE  = 192,
  parameter int CW        = (NCORE > 1) ? $clog2(NCORE) : 1,
  parameter int MW        = (NMBOX > 1) ? $clog2(NMBOX) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DW-1:0]          rsp_rdata,
  input  logic [NCORE*NMBOX*DW-1:0] mbox_flat,
  input  logic [NCORE*NMBOX-1:0] ctrl_flat,
  output logic                   wr_en,
  output reg_kind_e              wr_kind,
  output logic [CW-1:0]          wr_core,
  output logic [MW-1:0]          wr_mbox,
  output logic [DW-1:0]          wr_data
);
  localparam int CTRL_END = CTRL_BASE + WORD_BYTES * NCORE;
  localparam int SET_END  = SET_BASE + BANK_BYTES * NCORE;
  localparam int CLR_END  = CLR_BASE + BANK_BYTES * NCORE;

  logic [31:0]   a32;
  reg_kind_e     kind;
  logic [CW-1:0] core;
  logic [MW-1:0] mbox;
  logic          accept;
  logic [DW-1:0] rd_word;

  assign a32 = 32'(req_addr);

  always_comb begin
    kind = REG_NONE;
    core = '0;
    mbox = '0;
    if (a32 >= 32'(CTRL_BASE) && a32 < 32'(CTRL_END)) begin
      kind = REG_CTRL;
      core = CW'((a32 - 32'(CTRL_BASE)) >> 2);
    end else if (a32 >= 32'(SET_BASE) && a32 < 32'(SET_END)) begin
      if (((a32 - 32'(SET_BASE)) >> 2) % 4 < 32'(NMBOX)) begin
        kind = REG_SET;
        core = CW'((a32 - 32'(SET_BASE)) >> 4);
        mbox = MW'((a32 - 32'(SET_BASE)) >> 2);
      end
    end else if (a32 >= 32'(CLR_BASE) && a32 < 32'(CLR_END)) begin
      if (((a32 - 32'(CLR_BASE)) >> 2) % 4 < 32'(NMBOX)) begin
        kind = REG_CLR;
        core = CW'((a32 - 32'(CLR_BASE)) >> 4);
        mbox = MW'((a32 - 32'(CLR_BASE)) >> 2);
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (kind)
      REG_CTRL: rd_word = DW'(ctrl_flat[32'(core) * NMBOX +: NMBOX]);
      REG_CLR:  rd_word = mbox_flat[(32'(core) * NMBOX + 32'(mbox)) * DW +: DW];
      default:  rd_word = '0;
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  assign wr_en   = accept && req_write && (kind != REG_NONE);
  assign wr_kind = kind;
  assign wr_core = core;
  assign wr_mbox = mbox;
  assign wr_data = req_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8: a stalled response is held unchanged
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R8: every accepted request produces a response next cycle
  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NMBOX = 4,
  parameter int DW    = 32,
  parameter int NPORT = 2,
  parameter int CW    = (NCORE > 1) ? $clog2(NCORE) : 1,
  parameter int MW    = (NMBOX > 1) ? $clog2(NMBOX) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en   [NPORT],
  input  reg_kind_e                 wr_kind [NPORT],
  input  logic [CW-1:0]             wr_core [NPORT],
  input  logic [MW-1:0]             wr_mbox [NPORT],
  input  logic [DW-1:0]             wr_data [NPORT],
  output logic [NCORE*NMBOX*DW-1:0] mbox_flat,
  output logic [NCORE*NMBOX-1:0]    ctrl_flat
);
  localparam int NWORD = NCORE * NMBOX;

  logic [DW-1:0]    mbox_q   [NWORD];
  logic [DW-1:0]    set_any  [NWORD];
  logic [DW-1:0]    clr_any  [NWORD];
  logic [NMBOX-1:0] ctrl_q   [NCORE];
  logic [NMBOX-1:0] ctrl_nxt [NCORE];

  always_comb begin
    for (int i = 0; i < NWORD; i++) begin
      set_any[i] = '0;
      clr_any[i] = '0;
    end
    for (int p = 0; p < NPORT; p++) begin
      for (int i = 0; i < NWORD; i++) begin
        if (wr_en[p] && (32'(wr_core[p]) * NMBOX + 32'(wr_mbox[p])) == i) begin
          if (wr_kind[p] == REG_SET) set_any[i] = set_any[i] | wr_data[p];
          if (wr_kind[p] == REG_CLR) clr_any[i] = clr_any[i] | wr_data[p];
        end
      end
    end
  end

  // lowest-numbered port is applied last and therefore wins
  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      ctrl_nxt[c] = ctrl_q[c];
      for (int p = NPORT - 1; p >= 0; p--) begin
        if (wr_en[p] && wr_kind[p] == REG_CTRL && 32'(wr_core[p]) == c)
          ctrl_nxt[c] = wr_data[p][NMBOX-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NWORD; i++) begin
      if (rst) mbox_q[i] <= '0;
      else     mbox_q[i] <= (mbox_q[i] & ~clr_any[i]) | set_any[i];
    end
    for (int c = 0; c < NCORE; c++) begin
      if (rst) ctrl_q[c] <= '0;
      else     ctrl_q[c] <= ctrl_nxt[c];
    end
  end

  for (genvar i = 0; i < NWORD; i++) begin : g_word
    assign mbox_flat[i*DW +: DW] = mbox_q[i];

    // R1: reset empties every mailbox
    assert_reset_zero_R1: assert property (@(posedge clk)
      rst |=> (mbox_q[i] == '0));

    // R6: requested set bits are present next cycle, whatever is cleared
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((mbox_q[i] & $past(set_any[i])) == $past(set_any[i])));

    // R3: a bit only drops where a clear was requested
    assert_clear_only_R3: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((($past(mbox_q[i]) & ~mbox_q[i]) & ~$past(clr_any[i])) == '0));
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assign ctrl_flat[c*NMBOX +: NMBOX] = ctrl_q[c];

    // R7: a port 0 write to this enable register is always kept
    assert_port0_wins_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_en[0] && wr_kind[0] == REG_CTRL && 32'(wr_core[0]) == c)
      |=> (ctrl_q[c] == $past(wr_data[0][NMBOX-1:0])));
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int NCORE = 4,
  parameter int NMBOX = 4,
  parameter int DW    = 32
) (
  input  logic [NCORE*NMBOX*DW-1:0] mbox_flat,
  input  logic [NCORE*NMBOX-1:0]    ctrl_flat,
  output logic [NCORE-1:0]          pending
);
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [NMBOX-1:0] hit;
    for (genvar m = 0; m < NMBOX; m++) begin : g_mbox
      assign hit[m] = ctrl_flat[c*NMBOX + m] && (|mbox_flat[(c*NMBOX + m)*DW +: DW]);
    end
    assign pending[c] = |hit;
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int NCORE     = 4,
  parameter int NMBOX     = 4,
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int NPORT     = 2,
  parameter int CTRL_BASE = 0,
  parameter int SET_BASE  = 128,
  parameter int CLR_BASE  = 192
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT-1:0]    req_valid,
  output logic [NPORT-1:0]    req_ready,
  input  logic [NPORT-1:0]    req_write,
  input  logic [NPORT*AW-1:0] req_addr,
  input  logic [NPORT*DW-1:0] req_wdata,
  output logic [NPORT-1:0]    rsp_valid,
  input  logic [NPORT-1:0]    rsp_ready,
  output logic [NPORT*DW-1:0] rsp_rdata,
  output logic [NCORE-1:0]    mbox_pending
);
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam int MW = (NMBOX > 1) ? $clog2(NMBOX) : 1;

  logic [NCORE*NMBOX*DW-1:0] mbox_flat;
  logic [NCORE*NMBOX-1:0]    ctrl_flat;
  logic                      wr_en   [NPORT];
  reg_kind_e                 wr_kind [NPORT];
  logic [CW-1:0]             wr_core [NPORT];
  logic [MW-1:0]             wr_mbox [NPORT];
  logic [DW-1:0]             wr_data [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_port #(
      .NCORE(NCORE), .NMBOX(NMBOX), .DW(DW), .AW(AW),
      .CTRL_BASE(CTRL_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE),
      .CW(CW), .MW(MW)
    ) u_port (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid[p]),
      .req_ready (req_ready[p]),
      .req_write (req_write[p]),
      .req_addr  (req_addr[p*AW +: AW]),
      .req_wdata (req_wdata[p*DW +: DW]),
      .rsp_valid (rsp_valid[p]),
      .rsp_ready (rsp_ready[p]),
      .rsp_rdata (rsp_rdata[p*DW +: DW]),
      .mbox_flat (mbox_flat),
      .ctrl_flat (ctrl_flat),
      .wr_en     (wr_en[p]),
      .wr_kind   (wr_kind[p]),
      .wr_core   (wr_core[p]),
      .wr_mbox   (wr_mbox[p]),
      .wr_data   (wr_data[p])
    );
  end

  mbx_store #(
    .NCORE(NCORE), .NMBOX(NMBOX), .DW(DW), .NPORT(NPORT), .CW(CW), .MW(MW)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_kind   (wr_kind),
    .wr_core   (wr_core),
    .wr_mbox   (wr_mbox),
    .wr_data   (wr_data),
    .mbox_flat (mbox_flat),
    .ctrl_flat (ctrl_flat)
  );

  mbx_irq #(
    .NCORE(NCORE), .NMBOX(NMBOX), .DW(DW)
  ) u_irq (
    .mbox_flat (mbox_flat),
    .ctrl_flat (ctrl_flat),
    .pending   (mbox_pending)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_chk
    // R5: a core whose mailboxes are all empty never shows pending
    assert_empty_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      (mbox_flat[c*NMBOX*DW +: NMBOX*DW] == '0) |-> !mbox_pending[c]);
    // R5: a core with all enables clear never shows pending
    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      (ctrl_flat[c*NMBOX +: NMBOX] == '0) |-> !mbox_pending[c]);
  end
endmodule

// File: tb/tb_mbx_doorbell.sv
module tb_mbx_doorbell;
  localparam int CLK_PERIOD = 10;
  localparam int NCORE = 4;
  localparam int NMBOX = 4;
  localparam int DW    = 32;
  localparam int AW    = 8;
  localparam int NPORT = 2;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NPORT-1:0]    req_valid = '0;
  logic [NPORT-1:0]    req_ready;
  logic [NPORT-1:0]    req_write = '0;
  logic [NPORT*AW-1:0] req_addr  = '0;
  logic [NPORT*DW-1:0] req_wdata = '0;
  logic [NPORT-1:0]    rsp_valid;
  logic [NPORT-1:0]    rsp_ready = '1;
  logic [NPORT*DW-1:0] rsp_rdata;
  logic [NCORE-1:0]    mbox_pending;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_doorbell #(.NCORE(NCORE), .NMBOX(NMBOX), .DW(DW), .AW(AW), .NPORT(NPORT)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mbox_pending(mbox_pending)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;   // expected read data (reads only)
    logic [3:0]  pend;  // expected mbox_pending after the access
    logic [3:0]  req;   // requirement number the row targets
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 8'h00, 32'h0,          32'h0,        4'b0000, 4'd4},  // R4 enable reads zero
    '{1'b1, 8'h90, 32'h5,          32'h0,        4'b0000, 4'd2},  // R2 set, still masked
    '{1'b0, 8'hD0, 32'h0,          32'h5,        4'b0000, 4'd3},  // R3 clear view reads contents
    '{1'b1, 8'h04, 32'h1,          32'h0,        4'b0010, 4'd5},  // R5 enable after doorbell
    '{1'b1, 8'h98, 32'h100,        32'h0,        4'b0010, 4'd2},
    '{1'b1, 8'hD0, 32'h4,          32'h0,        4'b0010, 4'd3},  // partial clear
    '{1'b1, 8'hD0, 32'h1,          32'h0,        4'b0000, 4'd5},  // empty, other mbox masked
    '{1'b1, 8'h04, 32'h4,          32'h0,        4'b0010, 4'd5},
    '{1'b0, 8'hD8, 32'h0,          32'h100,      4'b0010, 4'd3},
    '{1'b0, 8'h98, 32'h0,          32'h0,        4'b0010, 4'd10}, // R10 set view reads zero
    '{1'b1, 8'hBC, 32'h8000_0000,  32'h0,        4'b0010, 4'd2},
    '{1'b1, 8'h0C, 32'hFFFF_FFF8,  32'h0,        4'b1010, 4'd4},  // upper bits dropped
    '{1'b0, 8'h0C, 32'h0,          32'h8,        4'b1010, 4'd4},
    '{1'b1, 8'h40, 32'hFFFF_FFFF,  32'h0,        4'b1010, 4'd10}, // unmapped write
    '{1'b0, 8'h40, 32'h0,          32'h0,        4'b1010, 4'd10},
    '{1'b1, 8'hFC, 32'hFFFF_FFFF,  32'h0,        4'b0010, 4'd3},
    '{1'b1, 8'hD8, 32'h100,        32'h0,        4'b0000, 4'd3}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic drive(input int p, input logic wr, input logic [7:0] a, input logic [31:0] d);
    req_valid[p]          = 1'b1;
    req_write[p]          = wr;
    req_addr[p*AW +: AW]  = a;
    req_wdata[p*DW +: DW] = d;
  endtask

  task automatic idle(input int p);
    req_valid[p] = 1'b0;
    req_write[p] = 1'b0;
  endtask

  // single access on port 0 with rsp_ready high; result seen one cycle later
  task automatic op0(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk);
    drive(0, wr, a, d);
    @(negedge clk);
    idle(0);
    rd = rsp_rdata[0 +: DW];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 pending", 32'(mbox_pending), 32'h0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check("R1 req_ready", 32'(req_ready), 32'h3);
    op0(1'b0, 8'hC0, 32'h0, rd);
    check("R1 mailbox zero", rd, 32'h0);

    // table walk on port 0
    for (int i = 0; i < NVEC; i++) begin
      op0(TBL[i].wr, TBL[i].addr, TBL[i].data, rd);
      check($sformatf("R8 rsp row %0d", i), 32'(rsp_valid[0]), 32'h1);
      if (!TBL[i].wr)
        check($sformatf("R%0d rdata row %0d", TBL[i].req, i), rd, TBL[i].exp);
      else
        check($sformatf("R8 write rdata row %0d", i), rd, 32'h0);
      check($sformatf("R5 pending row %0d (R%0d)", i, TBL[i].req),
            32'(mbox_pending), 32'(TBL[i].pend));
    end

    // R6: set and clear of the same bit in one cycle
    op0(1'b1, 8'h84, 32'h9, rd);
    @(negedge clk);
    drive(0, 1'b1, 8'h84, 32'h8);
    drive(1, 1'b1, 8'hC4, 32'h9);
    @(negedge clk);
    idle(0); idle(1);
    op0(1'b0, 8'hC4, 32'h0, rd);
    check("R6 set wins", rd, 32'h8);

    // R7: both ports write core 0 enables in one cycle
    @(negedge clk);
    drive(0, 1'b1, 8'h00, 32'h1);
    drive(1, 1'b1, 8'h00, 32'h2);
    @(negedge clk);
    idle(0); idle(1);
    check("R7 pending masked", 32'(mbox_pending), 32'h0);
    op0(1'b0, 8'h00, 32'h0, rd);
    check("R7 port0 wins", rd, 32'h1);

    // R8: back-pressure on port 1
    @(negedge clk);
    rsp_ready[1] = 1'b0;
    drive(1, 1'b0, 8'hC4, 32'h0);
    @(negedge clk);
    drive(1, 1'b1, 8'h84, 32'h10);
    check("R8 rsp valid", 32'(rsp_valid[1]), 32'h1);
    check("R8 ready low", 32'(req_ready[1]), 32'h0);
    check("R8 rdata", rsp_rdata[DW +: DW], 32'h8);
    drive(0, 1'b0, 8'hC4, 32'h0);
    @(negedge clk);
    idle(0);
    check("R8 stalled write not taken", rsp_rdata[0 +: DW], 32'h8);
    check("R8 rsp held", 32'(rsp_valid[1]), 32'h1);
    check("R8 rdata held", rsp_rdata[DW +: DW], 32'h8);
    rsp_ready[1] = 1'b1;
    @(negedge clk);
    idle(1);
    check("R8 next response", 32'(rsp_valid[1]), 32'h1);
    check("R8 write rdata zero", rsp_rdata[DW +: DW], 32'h0);
    op0(1'b0, 8'hC4, 32'h0, rd);
    check("R8 write taken after release", rd, 32'h18);

    // R9: read and set of the same mailbox in one cycle
    @(negedge clk);
    drive(0, 1'b0, 8'hC4, 32'h0);
    drive(1, 1'b1, 8'h84, 32'h20);
    @(negedge clk);
    idle(0); idle(1);
    check("R9 old value", rsp_rdata[0 +: DW], 32'h18);
    op0(1'b0, 8'hC4, 32'h0, rd);
    check("R9 new value", rd, 32'h38);

    // R5: enabling mailbox 1 of core 0 raises its line
    op0(1'b1, 8'h00, 32'h2, rd);
    check("R5 core0 pending", 32'(mbox_pending), 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule